// File: doc/BRIEF.md
# Per-Pin Input Debounce Filter with Shared Prescaler

This block cleans up a vector of asynchronous general-purpose input pins before they reach edge and level detection logic. Each raw pin first passes through a two-stage synchronizer. Each pin then either passes straight to the filtered output or, when its own filter enable bit is set, goes through a glitch filter. That filter samples only on a common sampling tick.

A single divisor, 24 bits wide, sets the period of the sampling tick, and every filtered pin uses it. There is no per-pin rate. The tick rate is the bus clock rate divided by the divisor, so a divisor of 2000 on a 66 MHz clock gives roughly 33 kHz. An enabled pin takes a new value only when two successive ticks have sampled the same level. Any pulse shorter than one tick period is therefore discarded. The filtered vector feeds only the interrupt detection path. Software sets the enable vector and the divisor through a small register port with a combinational read.

Top module: `gdb_debounce_top`

## Requirements
- R1: After reset the enable vector reads 0 at offset 0x40, the divisor reads 0 at offset 0x44, and `filt_out` is all zeros.
- R2: The divisor register at offset 0x44 stores only write-data bits 23:0. Bits 31:24 of a read at 0x44 are always 0.
- R3: A pin whose enable bit is 0 shows the raw input level on `filt_out` exactly 3 cycles after the input changes (two synchronizer stages plus one output register).
- R4: The sampling tick repeats every L cycles, where L = 1 for a divisor of 0 or 1 and L = divisor otherwise. A write to offset 0x44 restarts the count, so the first tick falls in the L-th cycle after the write takes effect.
- R5: An enabled pin's output changes one cycle after a tick, and only when that tick samples the same synchronized level as the previous tick. A pulse held for fewer cycles than L never reaches the output.
- R6: Enable bit i at offset 0x40 (bit i is pin i) affects only pin i. Enabled and disabled pins coexist, and the disabled ones keep the 3-cycle latency.
- R7: When a pin's enable bit is cleared, its output takes the synchronized input in the cycle after the write takes effect, with no tick needed.
- R8: Writes to offsets other than 0x40 and 0x44 change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pin_raw | input | NPIN (32) | Asynchronous pin levels |
| filt_out | output | NPIN (32) | Filtered pin levels for interrupt detection |

## Verification
A disabled pin's result is due 3 cycles after the bench drives the input. An enabled pin's result is due one cycle after the second tick at or after the synchronized change. The bench locates those ticks from the cycle in which it wrote the divisor, counting multiples of L from that write. When an enable bit is cleared, the result is due 2 cycles after the write is presented. The driver pushes the cycle number, mask and expected value into the scoreboard queue. The monitor compares each item on the falling edge of exactly that cycle, and it also checks that the old value still holds one cycle earlier, so a result that arrives early or late is caught.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_DIVISOR = 8'h44;
endpackage

// File: rtl/gdb_sync.sv
module gdb_sync #(
  parameter int NPIN = 32,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] d,
  output logic [NPIN-1:0] q
);
  logic [NPIN-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gdb_prescaler.sv
module gdb_prescaler #(
  parameter int DIV_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             restart,
  output logic             tick,
  output logic [DIV_W-1:0] count
);
  // Divisor 0 and 1 both mean "every cycle".
  function automatic logic [DIV_W-1:0] period_of(input logic [DIV_W-1:0] dv);
    return (dv <= DIV_W'(1)) ? DIV_W'(1) : dv;
  endfunction

  logic [DIV_W-1:0] period;
  assign period = period_of(divisor);
  // >= also covers a divisor lowered below the running count.
  assign tick = (count >= period - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (restart) count <= '0;
    else if (tick)    count <= '0;
    else              count <= count + DIV_W'(1);
  end
endmodule

// File: rtl/gdb_pin_filter.sv
module gdb_pin_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  input  logic d,
  output logic q
);
  logic last_sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_sample <= 1'b0;
      q           <= 1'b0;
    end else if (!enable) begin
      last_sample <= d;
      q           <= d;
    end else if (tick) begin
      last_sample <= d;
      if (d == last_sample) q <= d;
    end
  end
endmodule

// File: rtl/gdb_regs.sv
module gdb_regs
  import gdb_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int DIV_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NPIN-1:0]   en_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              div_wr
);
  assign div_wr = we && (addr == OFS_DIVISOR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      div_q <= '0;
    end else if (we) begin
      if (addr == OFS_ENABLE) en_q <= wdata[NPIN-1:0];
      if (div_wr) div_q <= wdata[DIV_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == OFS_ENABLE)       rdata[NPIN-1:0] = en_q;
    else if (addr == OFS_DIVISOR) rdata[DIV_W-1:0] = div_q;
  end
endmodule

// File: rtl/gdb_debounce_top.sv
module gdb_debounce_top
  import gdb_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int DIV_W = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NPIN-1:0]   pin_raw,
  output logic [NPIN-1:0]   filt_out
);
  logic [NPIN-1:0]  sync_q;
  logic [NPIN-1:0]  en_q;
  logic [DIV_W-1:0] div_q;
  logic             div_wr;
  logic             tick;
  logic [DIV_W-1:0] pre_cnt;

  gdb_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(sync_q)
  );

  gdb_regs #(.NPIN(NPIN), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .en_q(en_q),
    .div_q(div_q), .div_wr(div_wr)
  );

  gdb_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .divisor(div_q), .restart(div_wr),
    .tick(tick), .count(pre_cnt)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    gdb_pin_filter u_filt (
      .clk(clk), .rst_n(rst_n), .enable(en_q[i]), .tick(tick),
      .d(sync_q[i]), .q(filt_out[i])
    );
  end
endmodule

// File: rtl/gdb_debounce_chk.sv
module gdb_debounce_chk
  import gdb_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int DIV_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NPIN-1:0]   sync_q,
  input logic [NPIN-1:0]   en_q,
  input logic [DIV_W-1:0]  div_q,
  input logic              tick,
  input logic [DIV_W-1:0]  pre_cnt,
  input logic [NPIN-1:0]   filt_out
);
  AST_DIV_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_DIVISOR) |-> (reg_rdata[DATA_W-1:DIV_W] == '0)); // R2

  AST_FAST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q <= DIV_W'(1)) |-> tick); // R4

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_DIVISOR) |=> (pre_cnt == '0)); // R4

  AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((filt_out ^ $past(sync_q)) & ~$past(en_q)) == '0)); // R3

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (((filt_out ^ $past(filt_out)) & $past(en_q)) == '0)); // R5

  AST_CHANGE_TO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (((filt_out ^ $past(filt_out)) & (filt_out ^ $past(sync_q)) & $past(en_q)) == '0)); // R5
endmodule

bind gdb_debounce_top gdb_debounce_chk #(.NPIN(NPIN), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .sync_q(sync_q), .en_q(en_q), .div_q(div_q),
  .tick(tick), .pre_cnt(pre_cnt), .filt_out(filt_out)
);

// File: tb/gdb_debounce_top_tb.sv
module gdb_debounce_top_tb;
  typedef struct {
    int          due;
    logic [31:0] mask;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pin_raw = '0;
  logic [31:0] filt_out;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  item_t sb[$];

  localparam logic [7:0] A_EN  = 8'h40;
  localparam logic [7:0] A_DIV = 8'h44;

  gdb_debounce_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_raw(pin_raw),
    .filt_out(filt_out)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every queued item on its due cycle.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (it.due != cyc || (filt_out & it.mask) != (it.exp & it.mask)) begin
        errors++;
        $display("FAIL %s cycle %0d due %0d got %h exp %h", it.tag, cyc,
                 it.due, filt_out & it.mask, it.exp & it.mask);
      end
    end
  end

  function automatic void push(int due, logic [31:0] mask, logic [31:0] exp, string tag);
    item_t it;
    it.due = due; it.mask = mask; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endfunction

  // First tick at or after cycle c; ticks fall at base, base+per, ...
  function automatic int next_tick(int base, int per, int c);
    if (c <= base) return base;
    return base + ((c - base + per - 1) / per) * per;
  endfunction

  task automatic check_val(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // All tasks are entered just after a falling edge.
  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain;
    wait (sb.size() == 0);
    @(negedge clk);
  endtask

  initial begin : main
    logic [31:0] v;
    int n, w, t1, t2, per, base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_EN, v);  check_val("R1 enable", v, 32'h0);
    rd(A_DIV, v); check_val("R1 divisor", v, 32'h0);
    check_val("R1 filt_out", filt_out, 32'h0);
    @(negedge clk);

    // R2 upper bits dropped
    wr(A_DIV, 32'hFF00_0005);
    rd(A_DIV, v); check_val("R2 divisor", v, 32'h0000_0005);
    @(negedge clk);

    // R8 other offsets
    wr(8'h48, 32'hFFFF_FFFF);
    wr(8'h00, 32'h1234_5678);
    rd(A_EN, v);  check_val("R8 enable", v, 32'h0);
    rd(A_DIV, v); check_val("R8 divisor", v, 32'h0000_0005);
    rd(8'h48, v); check_val("R8 read other", v, 32'h0);
    @(negedge clk);
    wr(A_DIV, 32'h0);

    // R3 bypass latency
    idle(4);
    n = cyc; pin_raw = 32'hA5A5_0F0F;
    push(n + 2, '1, 32'h0, "R3"); push(n + 3, '1, 32'hA5A5_0F0F, "R3");
    drain();
    n = cyc; pin_raw = 32'h5A5A_F0F0;
    push(n + 2, '1, 32'hA5A5_0F0F, "R3"); push(n + 3, '1, 32'h5A5A_F0F0, "R3");
    drain();

    // R4 enabled, divisor 0 gives a tick per cycle
    wr(A_EN, 32'hFFFF_FFFF);
    idle(4);
    n = cyc; pin_raw = 32'h0F0F_3333;
    push(n + 3, '1, 32'h5A5A_F0F0, "R4"); push(n + 4, '1, 32'h0F0F_3333, "R4");
    drain();

    // R4 divisor 6, tick phase taken from the write
    per = 6;
    w = cyc; wr(A_DIV, 32'd6); base = w + per;
    pin_raw = 32'h0; idle(30);
    n = cyc; pin_raw = 32'h3C3C_3C3C;
    t1 = next_tick(base, per, n + 2); t2 = t1 + per;
    push(t2, '1, 32'h0, "R4"); push(t2 + 1, '1, 32'h3C3C_3C3C, "R4");
    drain();

    // R6 partial enable
    pin_raw = 32'h0; idle(30);
    wr(A_EN, 32'h0000_FFFF); idle(4);
    n = cyc; pin_raw = 32'hFFFF_FFFF;
    t1 = next_tick(base, per, n + 2); t2 = t1 + per;
    push(n + 2, 32'hFFFF_0000, 32'h0, "R6");
    push(n + 3, 32'hFFFF_0000, 32'hFFFF_0000, "R6");
    push(t2, 32'h0000_FFFF, 32'h0, "R6");
    push(t2 + 1, 32'h0000_FFFF, 32'h0000_FFFF, "R6");
    drain();

    // R5 short pulse rejected
    pin_raw = 32'h0; wr(A_EN, 32'hFFFF_FFFF); idle(30);
    n = cyc; pin_raw = 32'hFFFF_FFFF;
    push(n + 5, '1, 32'h0, "R5"); push(n + 10, '1, 32'h0, "R5");
    push(n + 20, '1, 32'h0, "R5"); push(n + 30, '1, 32'h0, "R5");
    idle(2); pin_raw = 32'h0;
    drain();

    // R7 clearing enable bypasses the filter at once
    wr(A_DIV, 32'd50); idle(120);
    pin_raw = 32'hFFFF_0000; idle(3);
    w = cyc;
    push(w + 1, '1, 32'h0, "R7"); push(w + 2, '1, 32'hFFFF_0000, "R7");
    wr(A_EN, 32'h0);
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    wait (cyc > 100000);
    errors++;
    $display("FAIL watchdog cycle %0d", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule